// File: doc/BRIEF.md
# Glyph Alignment and Compositing Stage

This block is one stage of a raster pipeline that moves a scan line through in fixed-width pixel chunks. Each beat carries one chunk of pixels, the chunk's horizontal index, the current scan row, and one text item. The text item is a pixel position and a character code. The stage reads the matching row of the glyph's bitmap from a small font store held inside the block. It slides that row into register with the chunk and paints the item's ink colour over every pixel where the glyph has ink. All other pixels leave the stage exactly as they arrived.

The glyph row sits at the centre of a window three sections wide. It is then moved left or right by no more than the width of one chunk. Glyph columns that fall outside the chunk are dropped, so a character that straddles a chunk boundary is drawn in two parts by two beats. The chunk width in pixels and the bits per pixel are parameters. Bandwidth therefore scales with the parameters and the item logic does not change. With one bit per pixel, the paint step reduces to a masked set or a masked clear.

The work is split into three register stages: font lookup, alignment and paint. A valid flag and the chunk's index travel with the data through all three.

Top module: `glyph_chunk_compositor`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it has been low, `out_valid` is 0 and `out_chunk` and `out_chunk_x` are all zeros.
- R2: A beat taken with `in_valid` high at one rising edge shows on the outputs, with `out_valid` high and the same `out_chunk_x`, after the third rising edge counted from and including that one. The output valid pattern repeats the input valid pattern three edges later.
- R3: Row r of glyph c (c from 0 to 15, r from 0 to 7) is the low 8 bits of (c*8 + r)*157 + 61. Bit g of that row is glyph column g, and a 1 there means ink.
- R4: Pixel i of a chunk occupies bits [4i+3:4i] of the chunk word and sits at absolute column `in_chunk_x`*8 + i. Glyph column g is drawn at absolute column `item_x` + g.
- R5: The glyph row used is `in_row` - `item_y`. When that difference is below 0 or above 7, the chunk passes through unchanged.
- R6: The move from the centred position is bounded. When `item_x` - 8*`in_chunk_x` is -8 or less, or 8 or more, nothing is drawn. Glyph columns that land outside the chunk on either side are discarded. A glyph that straddles two chunks is drawn partly in each of them.
- R7: Each pixel whose glyph bit is 1 becomes `ink`. Every other pixel keeps its incoming value. This includes an ink of zero painted over a chunk of all ones.
- R8: Beats with `in_valid` low produce no output beat, and `out_chunk` and `out_chunk_x` hold their last values through such cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat present on the inputs |
| in_chunk | input | 32 | Incoming pixels, 8 pixels of 4 bits |
| in_chunk_x | input | 7 | Horizontal index of the chunk within the scan line |
| in_row | input | 10 | Current scan row |
| item_x | input | 10 | Left column of the text item |
| item_y | input | 10 | Top row of the text item |
| item_char | input | 4 | Character code |
| ink | input | 4 | Pixel value painted where the glyph has ink |
| out_valid | output | 1 | Beat present on the outputs |
| out_chunk | output | 32 | Painted pixels |
| out_chunk_x | output | 7 | Chunk index carried through with the beat |

## Verification
The properties require `in_valid` to be low while reset is held, because the stage valid flags are compared one edge apart from the moment reset is released. They treat every item field as meaningful only on beats where `in_valid` is high. The bench keeps to these assumptions in three ways:
- It holds `in_valid` low during reset, including a reset applied in the middle of a stream.
- On idle cycles it drives item fields deliberately different from the previous beat.
- Every beat it drives uses coordinates inside the 10-bit ranges, including the top corner of the coordinate space.

// File: rtl/glyph_comp_pkg.sv
package glyph_comp_pkg;

  // Raw font word for a flat glyph-row index (glyph * rows + row).
  function automatic int unsigned font_word(input int unsigned flat_index);
    return flat_index * 157 + 61;
  endfunction

  // Glyph row selected by the current scan row; may be negative.
  function automatic int row_offset(input int unsigned scan_row, input int unsigned top);
    return int'(scan_row) - int'(top);
  endfunction

  // Glyph left edge relative to the left edge of the chunk.
  function automatic int col_offset(input int unsigned left, input int unsigned chunk_idx,
                                    input int unsigned ppc);
    return int'(left) - int'(chunk_idx * ppc);
  endfunction

  // True when value lies in [lo, hi).
  function automatic logic in_span(input int value, input int lo, input int hi);
    return (value >= lo) && (value < hi);
  endfunction

endpackage

// File: rtl/glyph_font_rom.sv
module glyph_font_rom #(
  parameter int GLYPH_COUNT = 16,
  parameter int GLYPH_H     = 8,
  parameter int GLYPH_W     = 8,
  parameter int ADDR_W      = $clog2(GLYPH_COUNT * GLYPH_H)
) (
  input  logic               clk,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  output logic [GLYPH_W-1:0] q
);
  localparam int DEPTH = GLYPH_COUNT * GLYPH_H;

  logic [GLYPH_W-1:0] store [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++)
      store[a] = GLYPH_W'(glyph_comp_pkg::font_word(a));
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= store[addr];
  end
endmodule

// File: rtl/glyph_row_aligner.sv
module glyph_row_aligner #(
  parameter int PIX_PER_CHUNK = 8,
  parameter int BITS_PER_PIX  = 4,
  parameter int GLYPH_W       = 8,
  parameter int CX_W          = 7,
  parameter int SHIFT_W       = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  a_valid,
  input  logic                                  a_hit,
  input  logic [SHIFT_W-1:0]                    a_shift,
  input  logic [GLYPH_W-1:0]                    a_glyph,
  input  logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0] a_chunk,
  input  logic [CX_W-1:0]                       a_chunk_x,
  input  logic [BITS_PER_PIX-1:0]               a_ink,
  output logic                                  b_valid,
  output logic [PIX_PER_CHUNK-1:0]              b_mask,
  output logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0] b_chunk,
  output logic [CX_W-1:0]                       b_chunk_x,
  output logic [BITS_PER_PIX-1:0]               b_ink
);
  // Window: one chunk of margin on the left, the glyph, one chunk on the right.
  localparam int EXT_W = 2 * PIX_PER_CHUNK + GLYPH_W;

  logic [EXT_W-1:0]         centred;
  logic [EXT_W-1:0]         moved;
  logic [PIX_PER_CHUNK-1:0] mask_next;

  always_comb begin
    centred = '0;
    centred[PIX_PER_CHUNK +: GLYPH_W] = a_glyph;
    moved     = centred >> a_shift;
    mask_next = a_hit ? moved[PIX_PER_CHUNK-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid   <= 1'b0;
      b_mask    <= '0;
      b_chunk   <= '0;
      b_chunk_x <= '0;
      b_ink     <= '0;
    end else begin
      b_valid <= a_valid;
      if (a_valid) begin
        b_mask    <= mask_next;
        b_chunk   <= a_chunk;
        b_chunk_x <= a_chunk_x;
        b_ink     <= a_ink;
      end
    end
  end
endmodule

// File: rtl/chunk_painter.sv
module chunk_painter #(
  parameter int PIX_PER_CHUNK = 8,
  parameter int BITS_PER_PIX  = 4,
  parameter int CX_W          = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  p_valid,
  input  logic [PIX_PER_CHUNK-1:0]              p_mask,
  input  logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0] p_chunk,
  input  logic [CX_W-1:0]                       p_chunk_x,
  input  logic [BITS_PER_PIX-1:0]               p_ink,
  output logic                                  q_valid,
  output logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0] q_chunk,
  output logic [CX_W-1:0]                       q_chunk_x
);
  logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0] painted;

  generate
    if (BITS_PER_PIX == 1) begin : g_bitwise
      assign painted = p_ink[0] ? (p_chunk | p_mask) : (p_chunk & ~p_mask);
    end else begin : g_replace
      for (genvar i = 0; i < PIX_PER_CHUNK; i++) begin : g_pix
        assign painted[i*BITS_PER_PIX +: BITS_PER_PIX] =
          p_mask[i] ? p_ink : p_chunk[i*BITS_PER_PIX +: BITS_PER_PIX];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_chunk   <= '0;
      q_chunk_x <= '0;
    end else begin
      q_valid <= p_valid;
      if (p_valid) begin
        q_chunk   <= painted;
        q_chunk_x <= p_chunk_x;
      end
    end
  end
endmodule

// File: rtl/glyph_chunk_compositor.sv
module glyph_chunk_compositor #(
  parameter int PIX_PER_CHUNK = 8,
  parameter int BITS_PER_PIX  = 4,
  parameter int GLYPH_W       = 8,
  parameter int GLYPH_H       = 8,
  parameter int GLYPH_COUNT   = 16,
  parameter int XW            = 10,
  parameter int YW            = 10
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  input  logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0]       in_chunk,
  input  logic [XW-$clog2(PIX_PER_CHUNK)-1:0]         in_chunk_x,
  input  logic [YW-1:0]                               in_row,
  input  logic [XW-1:0]                               item_x,
  input  logic [YW-1:0]                               item_y,
  input  logic [$clog2(GLYPH_COUNT)-1:0]              item_char,
  input  logic [BITS_PER_PIX-1:0]                     ink,
  output logic                                        out_valid,
  output logic [PIX_PER_CHUNK*BITS_PER_PIX-1:0]       out_chunk,
  output logic [XW-$clog2(PIX_PER_CHUNK)-1:0]         out_chunk_x
);
  import glyph_comp_pkg::*;

  localparam int CHUNK_W = PIX_PER_CHUNK * BITS_PER_PIX;
  localparam int CX_W    = XW - $clog2(PIX_PER_CHUNK);
  localparam int ADDR_W  = $clog2(GLYPH_COUNT * GLYPH_H);
  localparam int SHIFT_W = $clog2(PIX_PER_CHUNK + GLYPH_W) + 1;

  // Stage 1 decode (named for the checker)
  int                 row_rel;
  int                 col_rel;
  logic               row_hit;
  logic               col_hit;
  logic               stage1_hit;
  logic [ADDR_W-1:0]  rom_addr;
  logic [SHIFT_W-1:0] shift_next;

  always_comb begin
    row_rel    = row_offset(in_row, item_y);
    col_rel    = col_offset(item_x, in_chunk_x, PIX_PER_CHUNK);
    row_hit    = in_span(row_rel, 0, GLYPH_H);
    col_hit    = in_span(col_rel, 1 - GLYPH_W, PIX_PER_CHUNK);
    stage1_hit = row_hit && col_hit;
    rom_addr   = ADDR_W'(int'(item_char) * GLYPH_H + (row_hit ? row_rel : 0));
    shift_next = col_hit ? SHIFT_W'(PIX_PER_CHUNK - col_rel) : '0;
  end

  // Stage 1 registers
  logic                 s1_valid;
  logic                 s1_hit;
  logic [SHIFT_W-1:0]   s1_shift;
  logic [CHUNK_W-1:0]   s1_chunk;
  logic [CX_W-1:0]      s1_chunk_x;
  logic [BITS_PER_PIX-1:0] s1_ink;
  logic [GLYPH_W-1:0]   rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_hit     <= 1'b0;
      s1_shift   <= '0;
      s1_chunk   <= '0;
      s1_chunk_x <= '0;
      s1_ink     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_hit     <= stage1_hit;
        s1_shift   <= shift_next;
        s1_chunk   <= in_chunk;
        s1_chunk_x <= in_chunk_x;
        s1_ink     <= ink;
      end
    end
  end

  glyph_font_rom #(
    .GLYPH_COUNT(GLYPH_COUNT), .GLYPH_H(GLYPH_H), .GLYPH_W(GLYPH_W), .ADDR_W(ADDR_W)
  ) u_font (
    .clk(clk), .rd_en(in_valid), .addr(rom_addr), .q(rom_q)
  );

  // Stage 2: alignment
  logic                    s2_valid;
  logic [PIX_PER_CHUNK-1:0] s2_mask;
  logic [CHUNK_W-1:0]      s2_chunk;
  logic [CX_W-1:0]         s2_chunk_x;
  logic [BITS_PER_PIX-1:0] s2_ink;

  glyph_row_aligner #(
    .PIX_PER_CHUNK(PIX_PER_CHUNK), .BITS_PER_PIX(BITS_PER_PIX), .GLYPH_W(GLYPH_W),
    .CX_W(CX_W), .SHIFT_W(SHIFT_W)
  ) u_align (
    .clk(clk), .rst_n(rst_n),
    .a_valid(s1_valid), .a_hit(s1_hit), .a_shift(s1_shift), .a_glyph(rom_q),
    .a_chunk(s1_chunk), .a_chunk_x(s1_chunk_x), .a_ink(s1_ink),
    .b_valid(s2_valid), .b_mask(s2_mask), .b_chunk(s2_chunk),
    .b_chunk_x(s2_chunk_x), .b_ink(s2_ink)
  );

  // Stage 3: paint
  chunk_painter #(
    .PIX_PER_CHUNK(PIX_PER_CHUNK), .BITS_PER_PIX(BITS_PER_PIX), .CX_W(CX_W)
  ) u_paint (
    .clk(clk), .rst_n(rst_n),
    .p_valid(s2_valid), .p_mask(s2_mask), .p_chunk(s2_chunk),
    .p_chunk_x(s2_chunk_x), .p_ink(s2_ink),
    .q_valid(out_valid), .q_chunk(out_chunk), .q_chunk_x(out_chunk_x)
  );
endmodule

// File: rtl/glyph_comp_checker.sv
module glyph_comp_checker #(
  parameter int P   = 8,
  parameter int BPP = 4,
  parameter int GW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s1_valid,
  input logic             s1_hit,
  input logic [GW-1:0]    rom_q,
  input logic             s2_valid,
  input logic [P-1:0]     s2_mask,
  input logic [P*BPP-1:0] s2_chunk,
  input logic             out_valid,
  input logic [P*BPP-1:0] out_chunk
);
  // R2: a beat moves one stage per edge
  a_r2_align_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);
  a_r2_paint_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid);

  // R8: no beat, no change on the outputs
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> (!out_valid && $stable(out_chunk)));

  // R5, R6: a missed row or column leaves an empty mask
  a_r5_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_hit) |=> (s2_mask == '0));

  // R6: clipping only removes ink columns, never adds them
  a_r6_clip_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ($countones(s2_mask) <= $past($countones(rom_q))));

  // R7: an empty mask passes the chunk through
  a_r7_empty_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_mask == '0) |=> (out_chunk == $past(s2_chunk)));
endmodule

bind glyph_chunk_compositor glyph_comp_checker #(
  .P(PIX_PER_CHUNK), .BPP(BITS_PER_PIX), .GW(GLYPH_W)
) u_checker (
  .clk(clk), .rst_n(rst_n),
  .s1_valid(s1_valid), .s1_hit(s1_hit), .rom_q(rom_q),
  .s2_valid(s2_valid), .s2_mask(s2_mask), .s2_chunk(s2_chunk),
  .out_valid(out_valid), .out_chunk(out_chunk)
);

// File: tb/tb_glyph_chunk_compositor.sv
module tb_glyph_chunk_compositor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_chunk = '0;
  logic [6:0]  in_chunk_x = '0;
  logic [9:0]  in_row = '0;
  logic [9:0]  item_x = '0;
  logic [9:0]  item_y = '0;
  logic [3:0]  item_char = '0;
  logic [3:0]  ink = '0;
  logic        out_valid;
  logic [31:0] out_chunk;
  logic [6:0]  out_chunk_x;

  always #2 clk = ~clk;

  glyph_chunk_compositor dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chunk(in_chunk),
    .in_chunk_x(in_chunk_x), .in_row(in_row), .item_x(item_x), .item_y(item_y),
    .item_char(item_char), .ink(ink), .out_valid(out_valid),
    .out_chunk(out_chunk), .out_chunk_x(out_chunk_x)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [6:0]  cx;
    logic [9:0]  row;
    logic [9:0]  ix;
    logic [9:0]  iy;
    logic [3:0]  ch;
    logic [3:0]  ik;
    logic [31:0] chunk;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 7'd2,   10'd3,    10'd16,   10'd0,    4'd1,  4'hF, 32'h0000_0000}, // R4 aligned
    '{4'd6, 7'd2,   10'd10,   10'd20,   10'd8,    4'd5,  4'hA, 32'h1234_5678}, // R6 right clip
    '{4'd6, 7'd3,   10'd10,   10'd20,   10'd8,    4'd5,  4'hA, 32'h1234_5678}, // R6 other half
    '{4'd6, 7'd1,   10'd0,    10'd15,   10'd0,    4'd15, 4'h3, 32'hDEAD_BEEF}, // R6 shift +7
    '{4'd6, 7'd1,   10'd7,    10'd1,    10'd0,    4'd2,  4'h9, 32'h0000_0000}, // R6 shift -7
    '{4'd6, 7'd1,   10'd7,    10'd0,    10'd0,    4'd2,  4'h9, 32'h0000_0000}, // R6 -8 none
    '{4'd6, 7'd1,   10'd7,    10'd16,   10'd0,    4'd2,  4'h9, 32'h0000_0000}, // R6 +8 none
    '{4'd5, 7'd12,  10'd100,  10'd96,   10'd100,  4'd3,  4'h7, 32'h5555_5555}, // R5 row 0
    '{4'd5, 7'd12,  10'd99,   10'd96,   10'd100,  4'd3,  4'h7, 32'h5555_5555}, // R5 row -1
    '{4'd5, 7'd12,  10'd108,  10'd96,   10'd100,  4'd3,  4'h7, 32'h5555_5555}, // R5 row 8
    '{4'd5, 7'd12,  10'd107,  10'd96,   10'd100,  4'd3,  4'h7, 32'h5555_5555}, // R5 row 7
    '{4'd7, 7'd0,   10'd0,    10'd0,    10'd0,    4'd0,  4'h0, 32'hFFFF_FFFF}, // R7 zero ink
    '{4'd3, 7'd127, 10'd1023, 10'd1020, 10'd1016, 4'd14, 4'hB, 32'h0F0F_0F0F}, // R3 top corner
    '{4'd3, 7'd5,   10'd50,   10'd43,   10'd45,   4'd9,  4'hC, 32'hA5A5_A5A5}  // R3 mid
  };

  typedef struct {
    int          due;
    logic [31:0] chunk;
    logic [6:0]  cx;
    int          rq;
  } exp_t;

  exp_t        expq[$];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  bit          mon_en = 1'b0;
  bit          have_last = 1'b0;
  logic [31:0] last_out = '0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model of R3..R7
  function automatic logic [31:0] model(input vec_t v);
    logic [31:0] res;
    int r;
    res = v.chunk;
    r = int'(v.row) - int'(v.iy);
    for (int i = 0; i < 8; i++) begin
      int g;
      g = int'(v.cx) * 8 + i - int'(v.ix);
      if (r >= 0 && r < 8 && g >= 0 && g < 8) begin
        int pat;
        pat = ((int'(v.ch) * 8 + r) * 157 + 61) % 256;
        if (((pat >> g) & 1) == 1) res[i*4 +: 4] = v.ik;
      end
    end
    return res;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic drive(input vec_t v);
    exp_t e;
    in_valid   = 1'b1;
    in_chunk   = v.chunk;
    in_chunk_x = v.cx;
    in_row     = v.row;
    item_x     = v.ix;
    item_y     = v.iy;
    item_char  = v.ch;
    ink        = v.ik;
    e.due   = cyc + 3;
    e.chunk = model(v);
    e.cx    = v.cx;
    e.rq    = int'(v.rq);
    expq.push_back(e);
  endtask

  task automatic idle();
    in_valid   = 1'b0;
    in_chunk   = ~in_chunk;
    in_chunk_x = in_chunk_x + 7'd1;
    item_char  = item_char + 4'd3;
    ink        = ~ink;
  endtask

  // Monitor: R2 timing, data, R8 hold
  always @(negedge clk) begin
    if (mon_en) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (!out_valid) begin
          fails++;
          $display("FAIL R2 beat missing at cycle %0d: out_valid=%0b expected 1", cyc, out_valid);
        end else if (out_chunk !== e.chunk || out_chunk_x !== e.cx) begin
          fails++;
          $display("FAIL R%0d chunk=%h x=%0d expected chunk=%h x=%0d",
                   e.rq, out_chunk, out_chunk_x, e.chunk, e.cx);
        end
      end else if (out_valid) begin
        checks++;
        fails++;
        $display("FAIL R8 unexpected out_valid=1 expected 0 at cycle %0d", cyc);
      end else if (have_last) begin
        checks++;
        if (out_chunk !== last_out) begin
          fails++;
          $display("FAIL R8 idle out_chunk=%h expected %h", out_chunk, last_out);
        end
      end
      if (out_valid) begin
        last_out  = out_chunk;
        have_last = 1'b1;
      end
    end
  end

  task automatic check_reset_state(input string what);
    checks++;
    if (out_valid !== 1'b0 || out_chunk !== 32'h0 || out_chunk_x !== 7'h0) begin
      fails++;
      $display("FAIL R1 %s valid=%0b chunk=%h x=%0d expected 0/0/0",
               what, out_valid, out_chunk, out_chunk_x);
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check_reset_state("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after release");
    mon_en = 1'b1;

    // Table walk, idle cycle after every third beat (R8)
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      if (k % 3 == 2) begin
        idle();
        @(negedge clk);
      end
    end
    idle();
    repeat (6) @(negedge clk);

    // Back-to-back glyph straddling two chunks (R6), streamed without gaps (R2)
    for (int c = 4; c < 7; c++) begin
      vec_t v;
      v = '{4'd6, 7'(c), 10'd2, 10'd37, 10'd0, 4'd11, 4'h6, 32'h8421_8421};
      drive(v);
      @(negedge clk);
    end
    idle();
    repeat (6) @(negedge clk);

    // Mid-stream reset (R1): beat in flight is dropped
    drive(VECS[0]);
    @(negedge clk);
    idle();
    mon_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_reset_state("mid-stream reset");
    expq.delete();
    have_last = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after mid-stream release");
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // Final beat after reset (R7 ink over mixed chunk)
    drive(VECS[13]);
    @(negedge clk);
    idle();
    repeat (6) @(negedge clk);

    if (expq.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R2 %0d beats never appeared, expected 0", expq.size());
    end
    finish_run();
  end
endmodule